// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block is a full-duplex asynchronous serial engine. Its transmit and receive paths are independent, and both can carry a frame at the same time. A parallel byte offered on the transmit handshake is turned into a serial frame on `serialOut`. A frame arriving on `serialIn` is turned back into a right-aligned byte, which is presented on the receive handshake together with framing and parity error flags. The valid/ready pairs on both sides are meant to connect directly to queues outside the block.

A five-bit line-control input sets the frame shape at run time: 5 to 8 data bits, an optional odd or even parity bit, and one or two stop bits. A 16-bit divisor sets the bit rate. A common tick runs at clock/divisor, and each bit lasts sixteen of these ticks. The transmitter copies the line control when it accepts a byte, and the receiver copies it when it sees a start edge. A change on that input therefore never alters a frame that is already in flight.

Top module: `serial_frame_engine`

## Requirements
- R1: After reset, `serialOut` is high, `txReady` is high and `rxValid` is low. Whenever the transmitter is idle (`txReady` high), `serialOut` is high.
- R2: A byte accepted by the transmitter (`txValid` and `txReady` high at a clock edge) makes `serialOut` low and `txReady` low from the next cycle. This is the single start bit. Every bit lasts 16 ticks, and a tick occurs every `divisor` clocks. A divisor of 0 behaves like 1.
- R3: Data bits follow the start bit, least significant bit first. `lineCtl[1:0]` sets their count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `txData` are not sent.
- R4: When `lineCtl[3]` is 1, one parity bit follows the data. `lineCtl[4]`=1 selects even parity, where the parity bit is the XOR of the data bits. `lineCtl[4]`=0 selects odd parity, which is the inverse.
- R5: The frame ends with one high stop bit, or with two when `lineCtl[2]` is 1. `txReady` stays low until the last stop bit has finished. A `lineCtl` value of 0x03 gives 8 data bits, no parity and one stop bit.
- R6: A received frame yields `rxData` right-aligned with its upper bits zero, and `rxValid` high. `rxValid` and `rxData` hold until `rxReady` is seen high.
- R7: A low pulse on `serialIn` that is no longer low at the middle of the start bit is discarded, and no byte results.
- R8: If the first stop bit samples low, `rxFrameErr` is 1 with that byte. Otherwise it is 0.
- R9: If parity is enabled and the received parity bit differs from the parity computed under R4, `rxParityErr` is 1 with that byte. Otherwise it is 0.
- R10: A transmit frame and a receive frame can run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Clocks per oversample tick (0 acts as 1) |
| lineCtl | input | 5 | Frame shape: [1:0] data length, [2] two stop bits, [3] parity enable, [4] even parity |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Transmitter idle and accepting |
| serialOut | output | 1 | Serial transmit line |
| serialIn | input | 1 | Serial receive line (asynchronous) |
| rxData | output | 8 | Received byte, right-aligned |
| rxValid | output | 1 | Received byte available |
| rxReady | input | 1 | Received byte taken |
| rxFrameErr | output | 1 | First stop bit sampled low |
| rxParityErr | output | 1 | Parity bit mismatch |

## Verification
The bench uses the default oversample factor of 16. It drives `divisor` at 1 for most of the run, so that each bit lasts exactly 16 clocks and mid-bit sampling in the bench falls at fixed cycle offsets. A divisor of 3 shows that the bit period scales, and that the transmitter's first tick may fall anywhere in the divisor phase. A divisor of 0 shows that the zero case behaves like 1. Every `lineCtl` shape in the table runs as a simultaneous send-and-receive pair, which brings every data length, both parity senses and both stop counts into play on both paths together.

// File: rtl/asp_pkg.sv
package asp_pkg;

  // Largest data length the line-control encoding can select
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [3:0] dataBits;
    logic       twoStop;
    logic       parEn;
    logic       parEven;
  } frame_cfg_t;

  // Strobes and frame settings from control to datapath
  typedef struct packed {
    logic       txLoad;
    logic       txShift;
    logic       txParity;
    logic       txStop;
    logic       txParEven;
    logic       rxStart;
    logic       rxSample;
    logic       rxParSample;
    logic       rxStopSample;
    logic [3:0] rxDataBits;
    logic       rxParEn;
    logic       rxParEven;
  } ctl_strobe_t;

  function automatic frame_cfg_t decodeLineCtl(input logic [4:0] lc);
    frame_cfg_t c;
    c.dataBits = 4'd5 + {2'b00, lc[1:0]};
    c.twoStop  = lc[2];
    c.parEn    = lc[3];
    c.parEven  = lc[4];
    return c;
  endfunction

endpackage

// File: rtl/asp_baud.sv
module asp_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (divisor == '0) ? '0 : divisor - 1'b1;
    tick  = (divCnt >= limit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // Tick spacing never exceeds the divisor period
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt > limit) |=> (divCnt == '0)) else $error("divider overran"); // R2
endmodule

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [4:0]  lineCtl,
  input  logic        txValid,
  output logic        txReady,
  input  logic        rxLine,
  output ctl_strobe_t strb
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} phase_t;

  phase_t     txPh, rxPh;
  logic [CW-1:0] txTick, rxTick;
  logic [3:0] txBit, rxBit;
  frame_cfg_t txCfg;
  logic [3:0] rxBits;
  logic       rxParEn, rxParEven;
  logic       txBitEnd, rxBitEnd, txLastData, rxLastData;

  always_comb begin
    txBitEnd   = tick && (txTick == LAST);
    rxBitEnd   = tick && (rxTick == LAST);
    txLastData = (txBit == txCfg.dataBits - 4'd1);
    rxLastData = (rxBit == rxBits - 4'd1);
    txReady    = (txPh == S_IDLE);

    strb            = '0;
    strb.txParEven  = txCfg.parEven;
    strb.rxDataBits = rxBits;
    strb.rxParEn    = rxParEn;
    strb.rxParEven  = rxParEven;

    strb.txLoad = (txPh == S_IDLE) && txValid;
    if (txBitEnd) begin
      unique case (txPh)
        S_START: strb.txShift = 1'b1;
        S_DATA: begin
          if (!txLastData)      strb.txShift  = 1'b1;
          else if (txCfg.parEn) strb.txParity = 1'b1;
          else                  strb.txStop   = 1'b1;
        end
        S_PAR:   strb.txStop = 1'b1;
        default: ;
      endcase
    end

    strb.rxStart = (rxPh == S_IDLE) && !rxLine;
    if (rxBitEnd) begin
      unique case (rxPh)
        S_DATA:  strb.rxSample     = 1'b1;
        S_PAR:   strb.rxParSample  = 1'b1;
        S_STOP:  strb.rxStopSample = 1'b1;
        default: ;
      endcase
    end
  end

  // Transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh   <= S_IDLE;
      txTick <= '0;
      txBit  <= '0;
      txCfg  <= '0;
    end else if (txPh == S_IDLE) begin
      if (txValid) begin
        txCfg  <= decodeLineCtl(lineCtl);
        txPh   <= S_START;
        txTick <= '0;
      end
    end else if (tick) begin
      txTick <= txBitEnd ? '0 : txTick + 1'b1;
      if (txBitEnd) begin
        unique case (txPh)
          S_START: begin
            txPh  <= S_DATA;
            txBit <= '0;
          end
          S_DATA: begin
            if (txLastData) begin
              txBit <= '0;
              txPh  <= txCfg.parEn ? S_PAR : S_STOP;
            end else begin
              txBit <= txBit + 4'd1;
            end
          end
          S_PAR: begin
            txPh  <= S_STOP;
            txBit <= '0;
          end
          S_STOP: begin
            if (txCfg.twoStop && (txBit == '0)) txBit <= 4'd1;
            else                                txPh  <= S_IDLE;
          end
          default: txPh <= S_IDLE;
        endcase
      end
    end
  end

  // Receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh      <= S_IDLE;
      rxTick    <= '0;
      rxBit     <= '0;
      rxBits    <= 4'd8;
      rxParEn   <= 1'b0;
      rxParEven <= 1'b0;
    end else begin
      unique case (rxPh)
        S_IDLE: begin
          if (!rxLine) begin
            rxBits    <= 4'd5 + {2'b00, lineCtl[1:0]};
            rxParEn   <= lineCtl[3];
            rxParEven <= lineCtl[4];
            rxPh      <= S_START;
            rxTick    <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (rxTick == MID) begin
              rxTick <= '0;
              rxBit  <= '0;
              rxPh   <= rxLine ? S_IDLE : S_DATA;
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            rxTick <= rxBitEnd ? '0 : rxTick + 1'b1;
            if (rxBitEnd) begin
              if (rxPh == S_DATA) begin
                if (rxLastData) rxPh <= rxParEn ? S_PAR : S_STOP;
                else            rxBit <= rxBit + 4'd1;
              end else if (rxPh == S_PAR) begin
                rxPh <= S_STOP;
              end else begin
                rxPh <= S_IDLE;
              end
            end
          end
        end
      endcase
    end
  end

  AST_TX_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txLoad, strb.txShift, strb.txParity, strb.txStop})) else $error("tx strobes clash"); // R3
  AST_RX_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxStart, strb.rxSample, strb.rxParSample, strb.rxStopSample})) else $error("rx strobes clash"); // R6
  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (rxPh == S_START && tick && rxTick == MID && rxLine) |=> (rxPh == S_IDLE)) else $error("false start kept"); // R7
  AST_TX_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (txPh == S_DATA) |-> (txBit < txCfg.dataBits)) else $error("tx bit count overrun"); // R3
endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              serialIn,
  input  logic              rxReady,
  output logic              txLine,
  output logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  output logic              rxParityErr
);
  logic [DATA_W-1:0] txShiftReg, rxShiftReg;
  logic txParAcc, rxParAcc, rxParBad;
  logic [1:0] syncReg;

  assign rxLine = syncReg[1];

  // Transmit shifter and line register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      txParAcc   <= 1'b0;
      txLine     <= 1'b1;
    end else if (strb.txLoad) begin
      txShiftReg <= txData;
      txParAcc   <= 1'b0;
      txLine     <= 1'b0;
    end else if (strb.txShift) begin
      txLine     <= txShiftReg[0];
      txShiftReg <= txShiftReg >> 1;
      txParAcc   <= txParAcc ^ txShiftReg[0];
    end else if (strb.txParity) begin
      txLine     <= strb.txParEven ? txParAcc : ~txParAcc;
    end else if (strb.txStop) begin
      txLine     <= 1'b1;
    end
  end

  // Receive synchronizer, shifter and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg     <= 2'b11;
      rxShiftReg  <= '0;
      rxParAcc    <= 1'b0;
      rxParBad    <= 1'b0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxParityErr <= 1'b0;
    end else begin
      syncReg <= {syncReg[0], serialIn};
      if (strb.rxStart) begin
        rxShiftReg <= '0;
        rxParAcc   <= 1'b0;
        rxParBad   <= 1'b0;
      end
      if (strb.rxSample) begin
        rxShiftReg <= {rxLine, rxShiftReg[DATA_W-1:1]};
        rxParAcc   <= rxParAcc ^ rxLine;
      end
      if (strb.rxParSample)
        rxParBad <= (rxLine != (strb.rxParEven ? rxParAcc : ~rxParAcc));
      if (strb.rxStopSample) begin
        rxData      <= rxShiftReg >> (4'(DATA_W) - strb.rxDataBits);
        rxFrameErr  <= ~rxLine;
        rxParityErr <= strb.rxParEn & rxParBad;
        rxValid     <= 1'b1;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  AST_RX_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid) else $error("rxValid dropped unread"); // R6
  AST_RX_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strb.rxStopSample) |=> $stable(rxData)) else $error("rxData moved unread"); // R6
endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
  import asp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [4:0]       lineCtl,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             serialOut,
  input  logic             serialIn,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             rxFrameErr,
  output logic             rxParityErr
);
  logic        tick;
  logic        rxLine;
  ctl_strobe_t strb;

  asp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .divisor(divisor), .tick(tick)
  );

  asp_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lineCtl(lineCtl),
    .txValid(txValid), .txReady(txReady), .rxLine(rxLine), .strb(strb)
  );

  asp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData),
    .serialIn(serialIn), .rxReady(rxReady), .txLine(serialOut),
    .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> serialOut) else $error("idle line low"); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (!serialOut && !txReady)) else $error("no start bit"); // R2
endmodule

// File: tb/serial_frame_engine_bench.sv
module serial_frame_engine_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] divisor;
  logic [4:0]  lineCtl;
  logic [7:0]  txData;
  logic        txValid, txReady, serialOut, serialIn;
  logic [7:0]  rxData;
  logic        rxValid, rxReady, rxFrameErr, rxParityErr;
  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  serial_frame_engine u_serial_frame_engine (
    .clk(clk), .rstN(rstN), .divisor(divisor), .lineCtl(lineCtl),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .serialOut(serialOut), .serialIn(serialIn), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .rxFrameErr(rxFrameErr),
    .rxParityErr(rxParityErr)
  );

  // {lineCtl(8 bits, low 5 used), tx byte, rx byte}
  localparam logic [23:0] VEC [9] = '{
    24'h03_A5_3C, 24'h00_15_0A, 24'h01_2B_31, 24'h02_55_7F, 24'h0B_81_7E,
    24'h1B_01_FF, 24'h07_C3_18, 24'h1E_40_33, 24'h0C_11_0E
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic int bitClk();
    return ((divisor == 0) ? 1 : int'(divisor)) * 16;
  endfunction

  function automatic int nBits(input logic [4:0] lc);
    return 5 + int'(lc[1:0]);
  endfunction

  function automatic logic [7:0] maskOf(input logic [4:0] lc, input logic [7:0] d);
    return d & 8'((1 << nBits(lc)) - 1);
  endfunction

  function automatic logic parOf(input logic [4:0] lc, input logic [7:0] d);
    logic p;
    p = ^maskOf(lc, d);
    return lc[4] ? p : ~p;
  endfunction

  task automatic txSend(input logic [7:0] d);
    @(negedge clk);
    txValid = 1'b1;
    txData  = d;
    @(negedge clk);
    txValid = 1'b0;
    txData  = 8'hFF;
  endtask

  task automatic txMon(input logic [4:0] lc, input logic [7:0] d);
    logic [7:0] got;
    int bc;
    bc  = bitClk();
    got = '0;
    while (serialOut !== 1'b0) @(negedge clk);
    repeat (bc / 2) @(negedge clk);
    chk("R2 start bit low", serialOut, 0);
    for (int i = 0; i < nBits(lc); i++) begin
      repeat (bc) @(negedge clk);
      got[i] = serialOut;
    end
    chk("R3 tx data lsb first", got, maskOf(lc, d));
    if (lc[3]) begin
      repeat (bc) @(negedge clk);
      chk("R4 tx parity bit", serialOut, parOf(lc, d));
    end
    repeat (bc) @(negedge clk);
    chk("R5 first stop high", serialOut, 1);
    chk("R5 busy in stop", txReady, 0);
    if (lc[2]) begin
      repeat (bc) @(negedge clk);
      chk("R5 second stop high", serialOut, 1);
      chk("R5 busy in second stop", txReady, 0);
    end
    repeat (bc) @(negedge clk);
    chk("R5 ready after frame", txReady, 1);
  endtask

  task automatic rxDrive(input logic [4:0] lc, input logic [7:0] d,
                         input logic flipPar, input logic badStop);
    int bc;
    bc = bitClk();
    @(negedge clk);
    serialIn = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < nBits(lc); i++) begin
      serialIn = d[i];
      repeat (bc) @(negedge clk);
    end
    if (lc[3]) begin
      serialIn = parOf(lc, d) ^ flipPar;
      repeat (bc) @(negedge clk);
    end
    serialIn = ~badStop;
    repeat (bc) @(negedge clk);
    if (lc[2]) begin
      serialIn = 1'b1;
      repeat (bc) @(negedge clk);
    end
    serialIn = 1'b1;
  endtask

  task automatic rxCheck(input string tag, input logic [7:0] expD,
                         input logic fe, input logic pe);
    repeat (4) @(negedge clk);
    chk({tag, " R6 rxValid set"}, rxValid, 1);
    chk({tag, " R6 rxData"}, rxData, expD);
    chk({tag, " R8 frame flag"}, rxFrameErr, fe);
    chk({tag, " R9 parity flag"}, rxParityErr, pe);
    repeat (3) @(negedge clk);
    chk({tag, " R6 rxValid held"}, rxValid, 1);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    chk({tag, " R6 rxValid cleared"}, rxValid, 0);
  endtask

  task automatic duplex(input logic [4:0] lc, input logic [7:0] td, input logic [7:0] rd);
    lineCtl = lc;
    fork
      txSend(td);
      txMon(lc, td);
      rxDrive(lc, rd, 1'b0, 1'b0);
    join
    rxCheck("R10 duplex", maskOf(lc, rd), 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog R1-all actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; divisor = 16'd1; lineCtl = 5'h03; txData = 8'h00;
    txValid = 1'b0; serialIn = 1'b1; rxReady = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset serialOut", serialOut, 1);
    chk("R1 reset txReady", txReady, 1);
    chk("R1 reset rxValid", rxValid, 0);

    foreach (VEC[i]) begin
      duplex(VEC[i][20:16], VEC[i][15:8], VEC[i][7:0]);
      repeat (10) @(negedge clk);
    end

    // R7: short low glitch is discarded
    @(negedge clk);
    serialIn = 1'b0;
    repeat (4) @(negedge clk);
    serialIn = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 glitch gives no byte", rxValid, 0);
    lineCtl = 5'h03;
    rxDrive(5'h03, 8'h5A, 1'b0, 1'b0);
    rxCheck("R7 after glitch", 8'h5A, 1'b0, 1'b0);

    // R8: low stop bit
    rxDrive(5'h03, 8'h96, 1'b0, 1'b1);
    rxCheck("R8 bad stop", 8'h96, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk("R8 no byte from trailing low", rxValid, 0);

    // R9: wrong parity, even then odd
    lineCtl = 5'h1B;
    rxDrive(5'h1B, 8'h6C, 1'b1, 1'b0);
    rxCheck("R9 even bad", 8'h6C, 1'b0, 1'b1);
    lineCtl = 5'h0A;
    rxDrive(5'h0A, 8'h25, 1'b1, 1'b0);
    rxCheck("R9 odd bad 7bit", 8'h25, 1'b0, 1'b1);

    // R2: other divisors
    divisor = 16'd3;
    repeat (20) @(negedge clk);
    duplex(5'h0F, 8'hE7, 8'h42);
    divisor = 16'd0;
    repeat (20) @(negedge clk);
    duplex(5'h03, 8'h99, 8'h66);

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule